// File: doc/BRIEF.md
# Radix-2 Butterfly Index Schedule Generator

This block walks the addressing schedule of an in-place radix-2 decimation-in-time transform. For a configured power-of-two length N it presents, one at a time, the pair of element indices that a butterfly combines and the twiddle-table index that scales the upper element. The triples drive register-file or memory address ports of a separate multiply/add-subtract datapath. Stages run from the narrowest span (2) to the full length N. Within a stage, groups are walked in ascending order, and within a group the lower index ascends.

The walk is free-running (one triple in each cycle) or stepped (one triple for each cycle in which `step` is high). A separate load-index mode walks N elements and pairs each destination index with its bit-reversed source index, for the reordered initial load. The block reports the schedule length when a run is started, flags the final triple, and pulses `done` once the schedule ends.

Top module: `bfly_sched_gen`

## Requirements
- R1: One cycle after an accepted `start`, `vec_len` holds (N/2)*log2(N) in butterfly mode or N in load-index mode. It keeps that value until the next `start`.
- R2: In butterfly mode the triples follow stage span 2, 4, ... N. Groups start at 0, span, 2*span, ..., and j ascends within a group. `lo_idx` = j and `hi_idx` = j + span/2.
- R3: `tw_idx` is 0 for the first triple of every group and grows by N/span for each following triple in that group.
- R4: In free-running mode (`step_mode`=0) `valid` is high in every cycle from the cycle after `start` up to and including the final triple, with one new triple per cycle. `last` is high only together with the final triple.
- R5: In stepped mode (`step_mode`=1) a triple is presented and consumed only in a cycle where `step` is high. With `step` low, `valid` is low and the indices hold.
- R6: `done` is high for exactly one cycle, in the cycle after the final triple, and `busy` is low from that cycle on.
- R7: In load-index mode (`bitrev_mode`=1) there are N triples for i = 0..N-1. `lo_idx` = i, `hi_idx` = i with its log2(N) low bits in reversed order, and `tw_idx` = 0.
- R8: An unsupported length (not a power of two, or below 2) sets `err`, gives `vec_len` = 0, and produces no `valid` and no `done`. `err` clears on the next `start` with a supported length.
- R9: `start` during a run restarts the schedule from its first triple. No triple is presented in a cycle where `start` is high.
- R10: After reset `valid`, `done`, `busy`, `err` and `vec_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Latch the configuration and begin (or restart) a schedule |
| len_n | input | MAX_LOG2N+1 | Transform length N |
| step_mode | input | 1 | 1: advance only on `step`; 0: free-running |
| bitrev_mode | input | 1 | 1: load-index walk; 0: butterfly walk |
| step | input | 1 | Advance request in stepped mode |
| valid | output | 1 | Current triple is presented and consumed this cycle |
| lo_idx | output | MAX_LOG2N | Lower element index (destination index in load mode) |
| hi_idx | output | MAX_LOG2N | Upper element index (bit-reversed source in load mode) |
| tw_idx | output | MAX_LOG2N | Twiddle-table index |
| last | output | 1 | Current valid triple is the final one |
| done | output | 1 | One-cycle pulse after the final triple |
| busy | output | 1 | A schedule is in progress |
| err | output | 1 | Last started length was unsupported |
| vec_len | output | VLW | Number of triples in the started schedule |

## Verification
The bench builds the block with its default MAX_LOG2N of 6. This covers every supported length from 2 to 64, including the largest schedule (192 triples) and its widest `vec_len`. It runs butterfly walks at N = 2, 8 and 64 free-running, at N = 16 stepped with irregular step gaps, and load-index walks at 8 and 32. It also covers a restart five triples into a run, and the lengths 0, 1 and 96, which must raise `err`.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic {
    WALK_BFLY  = 1'b0,
    WALK_BREV  = 1'b1
  } walk_kind_e;

endpackage

// File: rtl/bfly_cfg_decode.sv
module bfly_cfg_decode #(
  parameter int MAX_LOG2N = 6,
  parameter int NW        = MAX_LOG2N + 1,
  parameter int LW        = 3,
  parameter int VLW       = 8
) (
  input  logic [NW-1:0]  len_n,
  input  logic           brev,
  output logic           ok,
  output logic [LW-1:0]  log2n,
  output logic [VLW-1:0] vlen
);

  int prod;

  always_comb begin
    ok    = (len_n > NW'(1)) && ((len_n & (len_n - NW'(1))) == '0);
    log2n = '0;
    for (int b = 0; b < NW; b++) begin
      if (len_n[b]) log2n = LW'(b);
    end
    prod = (int'(len_n) >> 1) * int'(log2n);
    if (!ok)       vlen = '0;
    else if (brev) vlen = VLW'(len_n);
    else           vlen = VLW'(prod);
  end

endmodule

// File: rtl/bfly_stage_walker.sv
module bfly_stage_walker #(
  parameter int IW = 6,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [LW-1:0] log2n,
  output logic [IW-1:0] lo,
  output logic [IW-1:0] hi,
  output logic [IW-1:0] tw,
  output logic          is_last
);

  logic [LW-1:0] st_q, st_d;
  logic [IW-1:0] gi_q, gi_d;
  logic [IW-1:0] jo_q, jo_d;
  logic [IW-1:0] half;
  logic [IW:0]   span;
  logic [IW:0]   nlen;
  logic          grp_end, stage_end, jo_end;
  logic          en;

  always_comb begin
    half      = IW'(1) << st_q;
    span      = {1'b0, half} << 1;
    nlen      = (IW+1)'(1) << log2n;
    grp_end   = ({1'b0, gi_q} + span) == nlen;
    stage_end = st_q == (log2n - LW'(1));
    jo_end    = jo_q == (half - IW'(1));
    is_last   = jo_end & grp_end & stage_end;
    lo        = gi_q + jo_q;
    hi        = lo + half;
    tw        = jo_q << (log2n - LW'(1) - st_q);
  end

  always_comb begin
    en   = clr | adv;
    st_d = st_q;
    gi_d = gi_q;
    jo_d = jo_q;
    if (clr) begin
      st_d = '0;
      gi_d = '0;
      jo_d = '0;
    end else if (adv) begin
      if (jo_end) begin
        jo_d = '0;
        if (grp_end) begin
          gi_d = '0;
          st_d = st_q + LW'(1);
        end else begin
          gi_d = gi_q + span[IW-1:0];
        end
      end else begin
        jo_d = jo_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      gi_q <= '0;
      jo_q <= '0;
    end else if (en) begin
      st_q <= st_d;
      gi_q <= gi_d;
      jo_q <= jo_d;
    end
  end

  // twiddle index restarts at zero on every new group
  assert_tw_group_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && jo_end && !is_last) |=> (tw == '0));

endmodule

// File: rtl/bfly_brev_walker.sv
module bfly_brev_walker #(
  parameter int IW = 6,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [LW-1:0] log2n,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] rev,
  output logic          is_last
);

  logic [IW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] rev_full;
  logic [IW:0]   nlen;
  logic          en;

  for (genvar b = 0; b < IW; b++) begin : g_rev
    assign rev_full[b] = cnt_q[IW-1-b];
  end

  always_comb begin
    nlen    = (IW+1)'(1) << log2n;
    idx     = cnt_q;
    rev     = rev_full >> (LW'(IW) - log2n);
    is_last = {1'b0, cnt_q} == (nlen - (IW+1)'(1));
  end

  always_comb begin
    en    = clr | adv;
    cnt_d = clr ? '0 : cnt_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bfly_sched_gen.sv
module bfly_sched_gen
  import bfly_pkg::*;
#(
  parameter int MAX_LOG2N = 6,
  parameter int NW        = MAX_LOG2N + 1,
  parameter int VLW       = $clog2(((2**MAX_LOG2N)/2)*MAX_LOG2N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  len_n,
  input  logic           step_mode,
  input  logic           bitrev_mode,
  input  logic           step,
  output logic           valid,
  output logic [MAX_LOG2N-1:0] lo_idx,
  output logic [MAX_LOG2N-1:0] hi_idx,
  output logic [MAX_LOG2N-1:0] tw_idx,
  output logic           last,
  output logic           done,
  output logic           busy,
  output logic           err,
  output logic [VLW-1:0] vec_len
);

  localparam int IW = MAX_LOG2N;
  localparam int LW = $clog2(MAX_LOG2N + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic           cfg_ok;
  logic [LW-1:0]  cfg_log2n;
  logic [VLW-1:0] cfg_vlen;

  bfly_cfg_decode #(.MAX_LOG2N(MAX_LOG2N), .NW(NW), .LW(LW), .VLW(VLW)) i_dec (
    .len_n (len_n),
    .brev  (bitrev_mode),
    .ok    (cfg_ok),
    .log2n (cfg_log2n),
    .vlen  (cfg_vlen)
  );

  logic           busy_q, busy_d;
  logic           err_q, err_d;
  logic           done_q, done_d;
  logic           stepm_q, stepm_d;
  walk_kind_e     kind_q, kind_d;
  logic [LW-1:0]  log2n_q, log2n_d;
  logic [VLW-1:0] vlen_q, vlen_d;

  logic          fire, sel_last;
  logic [IW-1:0] bf_lo, bf_hi, bf_tw, br_idx, br_rev;
  logic          bf_last, br_last;

  assign fire = busy_q & ~start & (~stepm_q | step);

  bfly_stage_walker #(.IW(IW), .LW(LW)) i_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (start),
    .adv     (fire && kind_q == WALK_BFLY),
    .log2n   (log2n_q),
    .lo      (bf_lo),
    .hi      (bf_hi),
    .tw      (bf_tw),
    .is_last (bf_last)
  );

  bfly_brev_walker #(.IW(IW), .LW(LW)) i_brev (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (start),
    .adv     (fire && kind_q == WALK_BREV),
    .log2n   (log2n_q),
    .idx     (br_idx),
    .rev     (br_rev),
    .is_last (br_last)
  );

  always_comb begin
    sel_last = (kind_q == WALK_BREV) ? br_last : bf_last;
    valid    = fire;
    last     = fire & sel_last;
    if (kind_q == WALK_BREV) begin
      lo_idx = br_idx;
      hi_idx = br_rev;
      tw_idx = '0;
    end else begin
      lo_idx = bf_lo;
      hi_idx = bf_hi;
      tw_idx = bf_tw;
    end
    done    = done_q;
    busy    = busy_q;
    err     = err_q;
    vec_len = vlen_q;
  end

  always_comb begin
    busy_d  = busy_q;
    err_d   = err_q;
    stepm_d = stepm_q;
    kind_d  = kind_q;
    log2n_d = log2n_q;
    vlen_d  = vlen_q;
    done_d  = 1'b0;
    if (start) begin
      busy_d  = cfg_ok;
      err_d   = ~cfg_ok;
      stepm_d = step_mode;
      kind_d  = bitrev_mode ? WALK_BREV : WALK_BFLY;
      log2n_d = cfg_log2n;
      vlen_d  = cfg_vlen;
    end else if (fire && sel_last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      stepm_q <= 1'b0;
      kind_q  <= WALK_BFLY;
      log2n_q <= '0;
      vlen_q  <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      done_q <= done_d;
      if (start) begin
        stepm_q <= stepm_d;
        kind_q  <= kind_d;
        log2n_q <= log2n_d;
        vlen_q  <= vlen_d;
      end
    end
  end

  assert_hi_above_lo_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && kind_q == WALK_BFLY) |-> (hi_idx > lo_idx));

  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid |-> ({1'b0, hi_idx} < ((IW+1)'(1) << log2n_q)));

  assert_step_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_q && stepm_q && !step && !start) |=>
      ($stable(lo_idx) && $stable(hi_idx) && $stable(tw_idx)));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last |=> (done && !busy));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err |-> (!valid && !busy && !done));

  assert_no_triple_on_start_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |-> !valid);

endmodule

// File: tb/test_bfly_sched_gen.sv
module test_bfly_sched_gen;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 6;
  localparam int IW   = MAXL;
  localparam int NW   = MAXL + 1;
  localparam int VLW  = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start, step_mode, bitrev_mode, step;
  logic [NW-1:0]  len_n;
  logic           valid, last, done, busy, err;
  logic [IW-1:0]  lo_idx, hi_idx, tw_idx;
  logic [VLW-1:0] vec_len;

  bfly_sched_gen #(.MAX_LOG2N(MAXL)) i_bfly_sched_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .len_n(len_n),
    .step_mode(step_mode), .bitrev_mode(bitrev_mode), .step(step),
    .valid(valid), .lo_idx(lo_idx), .hi_idx(hi_idx), .tw_idx(tw_idx),
    .last(last), .done(done), .busy(busy), .err(err), .vec_len(vec_len)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef logic [3*IW:0] item_t;
  item_t exp_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    done_cnt = 0;
  string cur_tag = "R2 R3 R4";

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pop and compare every presented triple
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        chk({cur_tag, " R8 unexpected triple"}, int'({last, lo_idx, hi_idx, tw_idx}), -1);
      end else begin
        chk(cur_tag, int'({last, lo_idx, hi_idx, tw_idx}), int'(exp_q.pop_front()));
      end
    end
    if (rst_n && done) done_cnt++;
  end

  function automatic int lg2(input int n);
    int r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  task automatic push_bfly(input int n, input int lim);
    int total = (n / 2) * lg2(n);
    int cnt = 0;
    for (int size = 2; size <= n; size *= 2) begin
      int half = size / 2;
      int stride = n / size;
      for (int i = 0; i < n; i += size) begin
        int k = 0;
        for (int j = i; j < i + half; j++) begin
          if (cnt < lim)
            exp_q.push_back({(cnt == total - 1), IW'(j), IW'(j + half), IW'(k)});
          cnt++;
          k += stride;
        end
      end
    end
  endtask

  task automatic push_brev(input int n);
    int w = lg2(n);
    for (int i = 0; i < n; i++) begin
      int r = 0;
      for (int b = 0; b < w; b++) r = (r << 1) | ((i >> b) & 1);
      exp_q.push_back({(i == n - 1), IW'(i), IW'(r), IW'(0)});
    end
  endtask

  task automatic start_run(input int n, input bit brev, input bit stepm);
    @(posedge clk); #1;
    len_n = NW'(n); bitrev_mode = brev; step_mode = stepm; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_run(input bit stepm, input int exp_vlen);
    int d0 = done_cnt;
    int ph = 0;
    @(negedge clk);
    chk("R1 vec_len", int'(vec_len), exp_vlen);
    while (done_cnt == d0) begin
      @(posedge clk); #1;
      step = stepm ? ((ph % 3) != 2) : 1'b0;
      ph++;
    end
    step = 1'b0;
    chk("R6 all triples before done", exp_q.size(), 0);
    chk("R6 busy low after done", int'(busy), 0);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
  endtask

  task automatic bad_len(input int n);
    int d0 = done_cnt;
    start_run(n, 1'b0, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R8 err set", int'(err), 1);
    chk("R8 vec_len zero", int'(vec_len), 0);
    chk("R8 no done", done_cnt, d0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; step_mode = 1'b0; bitrev_mode = 1'b0;
    step = 1'b0; len_n = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 valid", int'(valid), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 vec_len", int'(vec_len), 0);

    // free-running butterfly walks
    cur_tag = "R2 R3 R4 N8";
    push_bfly(8, 1000);  start_run(8, 1'b0, 1'b0);  finish_run(1'b0, 12);
    cur_tag = "R2 R3 R4 N2";
    push_bfly(2, 1000);  start_run(2, 1'b0, 1'b0);  finish_run(1'b0, 1);
    cur_tag = "R2 R3 R4 N64";
    push_bfly(64, 1000); start_run(64, 1'b0, 1'b0); finish_run(1'b0, 192);

    // stepped walk with gaps
    cur_tag = "R5 R2 R3 N16 stepped";
    push_bfly(16, 1000); start_run(16, 1'b0, 1'b1); finish_run(1'b1, 32);

    // load-index walks
    cur_tag = "R7 N8 free";
    push_brev(8);  start_run(8, 1'b1, 1'b0);  finish_run(1'b0, 8);
    cur_tag = "R7 R5 N32 stepped";
    push_brev(32); start_run(32, 1'b1, 1'b1); finish_run(1'b1, 32);

    // restart five triples into a run
    cur_tag = "R9 restart N8";
    push_bfly(8, 5);
    push_bfly(8, 1000);
    @(posedge clk); #1;
    len_n = NW'(8); bitrev_mode = 1'b0; step_mode = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (5) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    finish_run(1'b0, 12);

    // unsupported lengths
    cur_tag = "R8 bad length";
    bad_len(6);
    bad_len(0);
    bad_len(1);
    bad_len(96);

    // recovery after error
    cur_tag = "R8 R2 R4 N4 after err";
    push_bfly(4, 1000); start_run(4, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 err cleared", int'(err), 0);
    finish_run(1'b0, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule